// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned integers of a configurable width. It uses nothing but comparison and subtraction. A small controller sequences a datapath that holds two working registers, one magnitude comparator and one subtractor. On each compute cycle the controller either takes one reduction step or closes the run.

A start pulse latches the two operands, and the engine is busy from that point. While it is busy, further start requests are ignored. On every clock the larger working value is reduced by the smaller one. Once the two values match, or once either value is zero, the engine stores the answer in a result register and raises done. The result and done then hold until the next accepted start or a reset.

Top module: `gcd_engine`

## Requirements
- R1: After reset is released, done is 0 and result is 0.
- R2: A start that is sampled while the engine is idle, or while done is high, latches op_x and op_y into the working registers. In the following cycle done is 0.
- R3: In each compute cycle where both working values are nonzero and unequal, exactly one step is taken. If A < B, B becomes B − A. Otherwise A becomes A − B.
- R4: For two nonzero operands, result equals their greatest common divisor.
- R5: If exactly one operand is zero, result equals the other operand. If both operands are zero, result is 0.
- R6: Let k be the number of subtraction steps that R3 requires. done rises exactly k+1 clock edges after the edge that sampled the accepted start.
- R7: While a computation is in progress, start and any change on op_x or op_y have no effect on result or latency.
- R8: While done is high and start is low, done stays high and result stays stable.
- R9: Asserting rst_n low during a computation aborts it: done is 0 and result is 0. A later start then runs normally.
- R10: The operand and result width is the parameter WIDTH, which defaults to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a computation |
| op_x | input | WIDTH | First operand |
| op_y | input | WIDTH | Second operand |
| result | output | WIDTH | GCD of the last completed run |
| done | output | 1 | High when result is valid |

## Verification
The bench builds the engine with WIDTH = 5. At that width every one of the 1024 operand pairs can be run, including all zero cases and the worst-case chain (31, 1), well within the cycle budget. For each pair, the exact latency and result are computed arithmetically in the bench. About a third of the pairs are run while start stays high and the operands are scrambled during the computation. This shows that requests made while busy are ignored. Separate directed runs cover a reset in the middle of a computation, and a restart issued directly from the done state.

// File: rtl/gcd_pkg.sv
// Package: shared controller state type for the GCD engine.
package gcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPUTE = 2'd1,
        ST_DONE    = 2'd2
    } gcd_state_t;
endpackage

// File: rtl/gcd_compare.sv
// Module: gcd_compare
// Magnitude comparator for the two working values.
// Assumes: unsigned operands of equal width; purely combinational.
module gcd_compare #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    output logic             a_lt_b,
    output logic             equal,
    output logic             any_zero
);
    // Relation flags consumed by the controller and the datapath.
    always_comb begin
        a_lt_b   = (a_val < b_val);
        equal    = (a_val == b_val);
        any_zero = (a_val == '0) || (b_val == '0);
    end
endmodule

// File: rtl/gcd_datapath.sv
// Module: gcd_datapath
// Working registers A and B, a shared subtractor and the result register.
// Assumes: load, step and finish are mutually exclusive (ensured by controller).
module gcd_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             finish,
    input  logic             a_lt_b,
    input  logic [WIDTH-1:0] in_x,
    input  logic [WIDTH-1:0] in_y,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q,
    output logic [WIDTH-1:0] res_q
);
    logic [WIDTH-1:0] minuend;
    logic [WIDTH-1:0] subtrahend;
    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] final_val;

    // One subtractor: larger minus smaller.
    always_comb begin
        minuend    = a_lt_b ? b_q : a_q;
        subtrahend = a_lt_b ? a_q : b_q;
        diff       = minuend - subtrahend;
        final_val  = (a_q == '0) ? b_q : a_q;
    end

    // Working registers: load operands or apply one reduction step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= in_x;
            b_q <= in_y;
        end else if (step) begin
            if (a_lt_b) b_q <= diff;
            else        a_q <= diff;
        end
    end

    // Result register: captured once when the run closes.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_q <= '0;
        else if (finish) res_q <= final_val;
    end
endmodule

// File: rtl/gcd_ctrl.sv
// Module: gcd_ctrl
// Three-state controller: idle, compute, done.
// Assumes: start is sampled only in idle or done; ignored while computing.
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic equal,
    input  logic any_zero,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy,
    output logic done
);
    gcd_state_t state_q;
    gcd_state_t state_d;

    // Next-state and datapath command decode.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_COMPUTE;
                end
            end
            ST_COMPUTE: begin
                if (equal || any_zero) begin
                    finish  = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    step = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Status outputs decoded from the state.
    always_comb begin
        busy = (state_q == ST_COMPUTE);
        done = (state_q == ST_DONE);
    end
endmodule

// File: rtl/gcd_engine.sv
// Module: gcd_engine (top)
// Subtractive Euclid GCD: controller plus datapath.
// Assumes: start may be held or pulsed; requests while busy are dropped.
module gcd_engine #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    logic             load;
    logic             step;
    logic             finish;
    logic             busy;
    logic             a_lt_b;
    logic             equal;
    logic             any_zero;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [WIDTH-1:0] res_q;

    gcd_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .equal    (equal),
        .any_zero (any_zero),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .busy     (busy),
        .done     (done)
    );

    gcd_compare #(.WIDTH(WIDTH)) i_cmp (
        .a_val    (a_q),
        .b_val    (b_q),
        .a_lt_b   (a_lt_b),
        .equal    (equal),
        .any_zero (any_zero)
    );

    gcd_datapath #(.WIDTH(WIDTH)) i_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .finish (finish),
        .a_lt_b (a_lt_b),
        .in_x   (op_x),
        .in_y   (op_y),
        .a_q    (a_q),
        .b_q    (b_q),
        .res_q  (res_q)
    );

    // Drive the result port from the result register.
    always_comb result = res_q;
endmodule

// File: rtl/gcd_engine_checker.sv
// Module: gcd_engine_checker
// Temporal properties of gcd_engine; attached with bind below.
module gcd_engine_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] op_x,
    input logic [WIDTH-1:0] op_y,
    input logic [WIDTH-1:0] result,
    input logic             done,
    input logic             busy,
    input logic [WIDTH-1:0] a_val,
    input logic [WIDTH-1:0] b_val
);
    logic [WIDTH:0] pair_sum;
    logic           reducible;

    // Sum of the working values and the reduce condition.
    always_comb begin
        pair_sum  = {1'b0, a_val} + {1'b0, b_val};
        reducible = busy && (a_val != b_val) && (a_val != '0) && (b_val != '0);
    end

    a_r2_load_operands: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && a_val == $past(op_x) && b_val == $past(op_y)));

    a_r3_one_step_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        reducible |=> (busy && pair_sum < $past(pair_sum)));

    a_r6_done_follows_compute: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));
endmodule

bind gcd_engine gcd_engine_checker #(.WIDTH(WIDTH)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_x   (op_x),
    .op_y   (op_y),
    .result (result),
    .done   (done),
    .busy   (busy),
    .a_val  (a_q),
    .b_val  (b_q)
);

// File: tb/test_gcd_engine.sv
// Bench: exhaustive operand sweep of gcd_engine at WIDTH = 5.
module test_gcd_engine;
    localparam int W      = 5;
    localparam int NVAL   = 1 << W;
    localparam int WD_MAX = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_x = '0;
    logic [W-1:0] op_y = '0;
    logic [W-1:0] result;
    logic         done;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    gcd_engine #(.WIDTH(W)) i_gcd_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_x(op_x), .op_y(op_y), .result(result), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WD_MAX) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", WD_MAX);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_gcd(input int x, input int y);
        int a = x;
        int b = y;
        while (b != 0) begin
            int t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int ref_steps(input int x, input int y);
        int a = x;
        int b = y;
        int k = 0;
        while (a != 0 && b != 0 && a != b) begin
            if (a < b) b = b - a;
            else       a = a - b;
            k++;
        end
        return k;
    endfunction

    // Launch one run; optionally keep start high and scramble operands.
    task automatic run_pair(input int x, input int y, input bit disturb);
        int cnt;
        int exp_res;
        @(negedge clk);
        op_x  = W'(x);
        op_y  = W'(y);
        start = 1'b1;
        @(negedge clk);
        check("R2 done low after start", int'(done), 0);
        if (disturb) begin
            op_x  = W'(~x);
            op_y  = W'(x + 3);
            start = 1'b1;       // R7: held request while busy
        end else begin
            start = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (done) start = 1'b0;
        end
        start = 1'b0;
        exp_res = (x == 0) ? y : ((y == 0) ? x : ref_gcd(x, y));
        if (x == 0 || y == 0)
            check("R5 zero operand result", int'(result), exp_res);
        else if (disturb)
            check("R7 result unaffected while busy", int'(result), exp_res);
        else
            check("R4 gcd result", int'(result), exp_res);
        check(disturb ? "R7 latency unaffected" : "R6 latency", cnt, ref_steps(x, y) + 1);
    endtask

    initial begin
        int held;
        repeat (3) @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 result after reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after release", int'(done), 0);
        check("R1 result after release", int'(result), 0);

        // R4 R5 R6 R7 R10: all pairs of the WIDTH = 5 build.
        for (int x = 0; x < NVAL; x++) begin
            for (int y = 0; y < NVAL; y++) begin
                run_pair(x, y, ((x + y) % 3) == 0);
            end
        end

        // R8: result and done hold with start low.
        run_pair(18, 12, 1'b0);
        held = int'(result);
        repeat (4) @(negedge clk);
        check("R8 done held", int'(done), 1);
        check("R8 result held", int'(result), held);

        // R2: restart straight from done.
        run_pair(25, 15, 1'b0);
        check("R2 restart from done", int'(result), 5);

        // R9: reset in the middle of the longest chain.
        @(negedge clk);
        op_x = 5'd31; op_y = 5'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 done after abort", int'(done), 0);
        check("R9 result after abort", int'(result), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 stays idle after abort", int'(done), 0);
        run_pair(21, 14, 1'b0);
        check("R9 run after abort", int'(result), 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule